// File: doc/BRIEF.md
# Status-Cleared Interval Timer

This block gives a microprocessor a steady periodic event. It counts pulses of a slow timebase enable, nominally one every 100 ms. After a programmed number of those pulses (one to five) it sets a flag. The flag stays set until the processor performs a status read, and the status-read strobe clears it. The timer restarts by itself after each expiry, so events keep a constant spacing whether or not software has read the flag yet.

The multiple is written through the processor's address-decoded write path. A write to the timer's address loads the new multiple and presets the count to zero, so the next interval starts from that write. Writes to other addresses belong to neighbouring timebase registers and leave the timer alone. Everything runs on one clock with a synchronous active-high reset.

Top module: `ivl_status_timer`

## Requirements
- R1: After reset the flag is 0, the multiple is 5 and the tick count is 0.
- R2: A write with `wr_en` high and `wr_addr` equal to 2 loads the multiple from the whole 6-bit `wr_data` value; values 1 to 5 are used as they are.
- R3: A written value of 0 or of 6 or more loads a multiple of 5.
- R4: The flag becomes 1 at the clock edge that samples the Nth `tick` pulse after the last load or expiry, N being the multiple; cycles without `tick` do not advance the count.
- R5: After an expiry the count restarts at zero by itself, and the spacing of later expiries does not depend on when the flag is read.
- R6: A cycle with `stat_rd` high and no expiry clears the flag at the next edge; without `stat_rd` a set flag holds.
- R7: When an expiry and `stat_rd` fall in the same cycle, the flag is 1 afterwards.
- R8: A timer load sets the count to zero, discards a `tick` in the same cycle, and does not change the flag.
- R9: A write to any address other than 2, or data presented with `wr_en` low, changes neither the multiple nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 2 | Write address; 2 selects the timer |
| wr_data | input | 6 | Write data; the interval multiple |
| tick | input | 1 | One-cycle timebase enable (100 ms) |
| stat_rd | input | 1 | Status-read strobe; clears the flag |
| flag | output | 1 | Interval-elapsed latch |

## Verification
The bench walks every legal multiple and several out-of-range codes, checking the flag is still low one tick before the interval ends and high right after it; a design off by one tick, or one that used only the low data bits, would fail there. It spaces ticks with idle cycles to catch a design counting clocks, reads the flag partway into the next interval to catch a restart tied to the read, and collides expiry with a status read to catch a clear that drops the event. It also writes mid-count, writes together with a tick, and writes to a foreign address, which expose a missing preset, a tick that leaks through a load, or loose address decoding.

// File: rtl/ivl_status_timer.sv
module ivl_status_timer #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 6,
  parameter int MAX_MULT   = 5,
  parameter int TIMER_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic              stat_rd,
  output logic              flag
);

  localparam int MULT_W = $clog2(MAX_MULT + 1);
  localparam logic [MULT_W-1:0] MULT_MAX = MULT_W'(MAX_MULT);
  localparam logic [MULT_W-1:0] ONE      = MULT_W'(1);

  logic [MULT_W-1:0] mult_q, cnt_q, mult_new;
  logic              load, expire;

  assign load     = wr_en && (wr_addr == ADDR_W'(TIMER_ADDR));
  assign mult_new = (wr_data == '0 || wr_data > DATA_W'(MAX_MULT))
                    ? MULT_MAX : wr_data[MULT_W-1:0];
  assign expire   = !load && tick && (cnt_q == mult_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= MULT_MAX;
      cnt_q  <= '0;
    end else if (load) begin
      mult_q <= mult_new;
      cnt_q  <= '0;
    end else if (expire) begin
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q  <= cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (expire)  flag <= 1'b1;
    else if (stat_rd) flag <= 1'b0;
  end

endmodule

// File: rtl/ivl_status_timer_chk.sv
module ivl_status_timer_chk #(
  parameter int ADDR_W     = 2,
  parameter int MULT_W     = 3,
  parameter int MAX_MULT   = 5,
  parameter int TIMER_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              tick,
  input logic              stat_rd,
  input logic              flag,
  input logic [MULT_W-1:0] mult_q,
  input logic [MULT_W-1:0] cnt_q
);

  logic tload;
  assign tload = wr_en && (wr_addr == ADDR_W'(TIMER_ADDR));

  p_set_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !flag && !tick |=> !flag);

  p_rise_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !tick |=> !flag);

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (rst)
    flag && !stat_rd |=> flag);

  p_load_no_set_r8: assert property (@(posedge clk) disable iff (rst)
    tload && !flag |=> !flag);

  p_load_preset_r8: assert property (@(posedge clk) disable iff (rst)
    tload |=> cnt_q == '0);

  p_mult_range_r3: assert property (@(posedge clk) disable iff (rst)
    mult_q >= MULT_W'(1) && mult_q <= MULT_W'(MAX_MULT));

  p_count_below_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < mult_q);

endmodule

bind ivl_status_timer ivl_status_timer_chk #(
  .ADDR_W(ADDR_W), .MULT_W(MULT_W), .MAX_MULT(MAX_MULT), .TIMER_ADDR(TIMER_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .tick(tick),
  .stat_rd(stat_rd), .flag(flag), .mult_q(mult_q), .cnt_q(cnt_q)
);

// File: tb/ivl_status_timer_tb_top.sv
module ivl_status_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       stat_rd = 1'b0;
  logic       flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ivl_status_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .stat_rd(stat_rd), .flag(flag)
  );

  // {written value, expected interval in ticks}
  localparam logic [8:0] VEC [8] = '{
    {6'd1, 3'd1}, {6'd2, 3'd2}, {6'd3, 3'd3}, {6'd4, 3'd4},
    {6'd5, 3'd5}, {6'd0, 3'd5}, {6'd6, 3'd5}, {6'd63, 3'd5}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: flag=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d, input logic with_tick);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    chk("R1 reset flag", flag, 1'b0);
    // R1: default multiple of 5
    ticks(4);  chk("R1 default 5, four ticks", flag, 1'b0);
    ticks(1);  chk("R1 default 5, fifth tick", flag, 1'b1);
    rd();      chk("R6 read clears", flag, 1'b0);

    // R2 R3 R4: table walk
    for (int v = 0; v < 8; v++) begin
      wr(2'd2, VEC[v][8:3], 1'b0);
      rd();
      ticks(int'(VEC[v][2:0]) - 1);
      chk($sformatf("R2/R3 value %0d one tick early", VEC[v][8:3]), flag, 1'b0);
      ticks(1);
      chk($sformatf("R4 value %0d expiry", VEC[v][8:3]), flag, 1'b1);
      rd();
      chk("R6 read after expiry", flag, 1'b0);
    end

    // R4: idle cycles between ticks do not count
    wr(2'd2, 6'd2, 1'b0);
    ticks(1); idle(5);
    chk("R4 idle cycles ignored", flag, 1'b0);
    ticks(1);
    chk("R4 second spaced tick", flag, 1'b1);
    rd();

    // R5: restart independent of read timing
    wr(2'd2, 6'd3, 1'b0);
    ticks(3);  chk("R5 first expiry", flag, 1'b1);
    ticks(1);  idle(2);
    chk("R6 unread flag holds", flag, 1'b1);
    rd();
    ticks(1);  chk("R5 mid second interval", flag, 1'b0);
    ticks(1);  chk("R5 second expiry on schedule", flag, 1'b1);
    rd();

    // R7: expiry and read together
    wr(2'd2, 6'd1, 1'b0);
    ticks(1);  chk("R7 setup expiry", flag, 1'b1);
    tick = 1'b1; stat_rd = 1'b1; @(negedge clk); tick = 1'b0; stat_rd = 1'b0;
    chk("R7 set wins over read", flag, 1'b1);
    rd();      chk("R7 later read clears", flag, 1'b0);

    // R8: load presets count mid-interval
    wr(2'd2, 6'd3, 1'b0);
    ticks(2);
    wr(2'd2, 6'd3, 1'b0);
    ticks(2);  chk("R8 preset: two ticks after reload", flag, 1'b0);
    ticks(1);  chk("R8 preset: third tick after reload", flag, 1'b1);
    // R8: load leaves flag set
    wr(2'd2, 6'd2, 1'b0);
    chk("R8 load keeps flag", flag, 1'b1);
    rd();
    // R8: tick with load discarded
    wr(2'd2, 6'd2, 1'b1);
    ticks(1);  chk("R8 tick with load discarded", flag, 1'b0);
    ticks(1);  chk("R8 interval after load+tick", flag, 1'b1);
    rd();

    // R9: foreign address and unstrobed data ignored
    wr(2'd2, 6'd4, 1'b0);
    ticks(2);
    wr(2'd1, 6'd1, 1'b0);
    wr(2'd3, 6'd1, 1'b0);
    wr_addr = 2'd2; wr_data = 6'd1; @(negedge clk);
    ticks(1);  chk("R9 foreign writes ignored, tick 3", flag, 1'b0);
    ticks(1);  chk("R9 foreign writes ignored, tick 4", flag, 1'b1);
    rd();

    finish_run();
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

endmodule